// File: doc/BRIEF.md
# Dual-Master Interrupt Status Register

This block is the interrupt status register of a bus selector that serves two upstream masters. It gathers six event flags into one status word. Three of them track a live condition: the external interrupt line and one test-interrupt flag per master. They follow their source and are never touched by a register read. The other three record one-shot events: bus initialization finished, a channel switch onto a busy bus, and loss of the bus. These events are captured and held until a read of the register clears them. The clear happens on one chosen bit-clock pulse of the read data phase.

Each master has its own active-low interrupt output. That output is low whenever any flag in the master's own view is set and not masked by that master. The mask storage and the serial slave front end sit outside this block. The masks arrive as plain inputs. The read arrives as a strobe together with a running count of bit-clock pulses.

Top module: `dmsr_status`

## Requirements
- R1: A read, at any pulse count, leaves the external-interrupt flag (`status[0]`) and both test flags (`status[1]` for master 0, `status[2]` for master 1) unchanged.
- R2: `status[0]` is set one clock after `ext_irq_n` is sampled low. It clears one clock after `ext_irq_n` is sampled high. If the line is still low after a read, the flag and the interrupt remain asserted.
- R3: The test flag of master m is set one clock after `self_tst[m]` or `peer_tst[1-m]` is sampled high. It clears only once both are sampled low.
- R4: `status[3]` (initialization done), `status[4]` (bus sensor) and `status[5]` (bus lost) hold their value until a clock where `rd_en` is high and `rd_pulse` equals CLR_PULSE (default 2). At that clock they clear. Other pulse counts, or a pulse count of 2 with `rd_en` low, do not clear them.
- R5: When a set event and the read-clear fall on the same clock, the flag ends up set.
- R6: `status[4]` is set by `switch_p` only while `bus_busy` is high and `recov_req` is low. `init_done_p` sets `status[3]` and `lost_p` sets `status[5]`.
- R7: A synchronous reset clears all six flags and drives `irq_n` to 2'b11.
- R8: Master m sees a 5-bit view {lost, sensor, init, own test flag, external}, with the external flag at bit 0. Its mask is `irq_mask[5m+4:5m]`, where a 1 masks the bit. `irq_n[m]` is low on the same clock as the status it reflects if any unmasked view bit is set. The masks do not alter `status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_irq_n | input | 1 | External interrupt level, active low |
| self_tst | input | 2 | Test bit each master sets to interrupt itself |
| peer_tst | input | 2 | Test bit each master sets to interrupt the other master |
| init_done_p | input | 1 | One-clock pulse: bus initialization finished |
| switch_p | input | 1 | One-clock pulse: channel switch performed |
| bus_busy | input | 1 | Bus was not idle at the switch |
| recov_req | input | 1 | Bus recovery or initialization was requested |
| lost_p | input | 1 | One-clock pulse: bus lost |
| rd_en | input | 1 | Status register read data phase in progress |
| rd_pulse | input | PULSE_W | Bit-clock pulse count within the read, first pulse is 1 |
| irq_mask | input | 10 | Per-master interrupt masks, master m at bits 5m+4..5m |
| status | output | 6 | Status word: lost, sensor, init, test1, test0, external |
| irq_n | output | 2 | Per-master interrupt, active low |

## Verification
The bench uses the default parameters: CLR_PULSE of 2 and a 4-bit pulse count. With these values it can drive a read both at pulse 1, which must not clear, and at pulse 2, which must clear. It can also drive pulse 2 with the read strobe low. The stimulus table holds each sticky event through a read. It also holds each level source through a read, and lines up a set and a clear on the same clock. Directed tests then exercise each master's mask separately and check that a mid-run reset clears flags that were already set.

// File: rtl/dmsr_pkg.sv
package dmsr_pkg;
    localparam int NUM_MST = 2;
    localparam int FLAG_W  = 6;
    localparam int VIEW_W  = 5;
    localparam int NUM_LVL = 3;
    localparam int NUM_STK = 3;

    // status word bit positions
    localparam int B_EXT  = 0;
    localparam int B_TST0 = 1;
    localparam int B_INIT = 3;
    localparam int B_SENS = 4;
    localparam int B_LOST = 5;

    // per-master view bit positions
    localparam int V_EXT  = 0;
    localparam int V_TST  = 1;
    localparam int V_INIT = 2;
    localparam int V_SENS = 3;
    localparam int V_LOST = 4;

    typedef struct packed {
        logic flag;
    } flag_state_t;

    typedef struct packed {
        logic irq_n;
    } irq_state_t;
endpackage

// File: rtl/dmsr_level_flag.sv
module dmsr_level_flag
    import dmsr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic nxt_o,
    output logic flag_o
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.flag = level_i;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign nxt_o  = rst ? 1'b0 : st_d.flag;
    assign flag_o = st_q.flag;
endmodule

// File: rtl/dmsr_sticky_flag.sv
module dmsr_sticky_flag
    import dmsr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic nxt_o,
    output logic flag_o
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.flag = 1'b0;
        if (set_i) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign nxt_o  = rst ? 1'b0 : st_d.flag;
    assign flag_o = st_q.flag;
endmodule

// File: rtl/dmsr_irq_merge.sv
module dmsr_irq_merge
    import dmsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [VIEW_W-1:0] view_i,
    input  logic [VIEW_W-1:0] mask_i,
    output logic              irq_n_o
);
    irq_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.irq_n = ~|(view_i & ~mask_i);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{irq_n: 1'b1};
        else     st_q <= st_d;
    end

    assign irq_n_o = st_q.irq_n;
endmodule

// File: rtl/dmsr_status.sv
module dmsr_status
    import dmsr_pkg::*;
#(
    parameter int PULSE_W   = 4,
    parameter int CLR_PULSE = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ext_irq_n,
    input  logic [NUM_MST-1:0]        self_tst,
    input  logic [NUM_MST-1:0]        peer_tst,
    input  logic                      init_done_p,
    input  logic                      switch_p,
    input  logic                      bus_busy,
    input  logic                      recov_req,
    input  logic                      lost_p,
    input  logic                      rd_en,
    input  logic [PULSE_W-1:0]        rd_pulse,
    input  logic [NUM_MST*VIEW_W-1:0] irq_mask,
    output logic [FLAG_W-1:0]         status,
    output logic [NUM_MST-1:0]        irq_n
);
    localparam logic [PULSE_W-1:0] CLR_VAL = PULSE_W'(CLR_PULSE);

    typedef struct packed {
        logic [NUM_LVL-1:0] lvl;
        logic [NUM_STK-1:0] set;
        logic               clr;
    } src_t;

    src_t src_d;
    logic [FLAG_W-1:0] flag_d, flag_q;

    always_comb begin
        src_d        = '0;
        src_d.lvl[0] = ~ext_irq_n;
        for (int m = 0; m < NUM_MST; m++)
            src_d.lvl[1+m] = self_tst[m] | peer_tst[NUM_MST-1-m];
        src_d.set[0] = init_done_p;
        src_d.set[1] = switch_p & bus_busy & ~recov_req;
        src_d.set[2] = lost_p;
        src_d.clr    = rd_en & (rd_pulse == CLR_VAL);
    end

    generate
        for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
            dmsr_level_flag u_lvl (
                .clk     (clk),
                .rst     (rst),
                .level_i (src_d.lvl[i]),
                .nxt_o   (flag_d[B_EXT+i]),
                .flag_o  (flag_q[B_EXT+i])
            );
        end
        for (genvar j = 0; j < NUM_STK; j++) begin : g_stk
            dmsr_sticky_flag u_stk (
                .clk     (clk),
                .rst     (rst),
                .set_i   (src_d.set[j]),
                .clr_i   (src_d.clr),
                .nxt_o   (flag_d[B_INIT+j]),
                .flag_o  (flag_q[B_INIT+j])
            );
        end
        for (genvar m = 0; m < NUM_MST; m++) begin : g_mst
            logic [VIEW_W-1:0] view;
            always_comb begin
                view         = '0;
                view[V_EXT]  = flag_d[B_EXT];
                view[V_TST]  = flag_d[B_TST0+m];
                view[V_INIT] = flag_d[B_INIT];
                view[V_SENS] = flag_d[B_SENS];
                view[V_LOST] = flag_d[B_LOST];
            end
            dmsr_irq_merge u_irq (
                .clk     (clk),
                .rst     (rst),
                .view_i  (view),
                .mask_i  (irq_mask[m*VIEW_W +: VIEW_W]),
                .irq_n_o (irq_n[m])
            );
        end
    endgenerate

    assign status = flag_q;
endmodule

// File: rtl/dmsr_status_chk.sv
module dmsr_status_chk
    import dmsr_pkg::*;
#(
    parameter int PULSE_W   = 4,
    parameter int CLR_PULSE = 2
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      ext_irq_n,
    input logic [NUM_MST-1:0]        self_tst,
    input logic [NUM_MST-1:0]        peer_tst,
    input logic                      switch_p,
    input logic                      bus_busy,
    input logic                      recov_req,
    input logic                      lost_p,
    input logic                      rd_en,
    input logic [PULSE_W-1:0]        rd_pulse,
    input logic [NUM_MST*VIEW_W-1:0] irq_mask,
    input logic [FLAG_W-1:0]         status,
    input logic [NUM_MST-1:0]        irq_n
);
    localparam logic [PULSE_W-1:0] CLR_VAL = PULSE_W'(CLR_PULSE);

    assert_read_keeps_ext_R1: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !ext_irq_n) |=> status[B_EXT]);

    assert_ext_follows_R2: assert property (@(posedge clk) disable iff (rst)
        ext_irq_n |=> !status[B_EXT]);

    assert_tst_follows_R3: assert property (@(posedge clk) disable iff (rst)
        (!self_tst[0] && !peer_tst[1]) |=> !status[B_TST0]);

    assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (status[B_LOST] && !(rd_en && rd_pulse == CLR_VAL)) |=> status[B_LOST]);

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
        lost_p |=> status[B_LOST]);

    assert_sensor_set_R6: assert property (@(posedge clk) disable iff (rst)
        (switch_p && bus_busy && !recov_req) |=> status[B_SENS]);

    assert_reset_state_R7: assert property (@(posedge clk)
        rst |=> (status == '0 && irq_n == 2'b11));

    assert_irq_view_R8: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (irq_n[0] == ~|({status[B_LOST], status[B_SENS], status[B_INIT],
                                  status[B_TST0], status[B_EXT]} & ~$past(irq_mask[VIEW_W-1:0]))));
endmodule

bind dmsr_status dmsr_status_chk #(.PULSE_W(PULSE_W), .CLR_PULSE(CLR_PULSE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ext_irq_n (ext_irq_n),
    .self_tst  (self_tst),
    .peer_tst  (peer_tst),
    .switch_p  (switch_p),
    .bus_busy  (bus_busy),
    .recov_req (recov_req),
    .lost_p    (lost_p),
    .rd_en     (rd_en),
    .rd_pulse  (rd_pulse),
    .irq_mask  (irq_mask),
    .status    (status),
    .irq_n     (irq_n)
);

// File: tb/sim_dmsr_status.sv
`timescale 1ns/1ps
module sim_dmsr_status;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_irq_n = 1'b1;
    logic [1:0] self_tst = '0, peer_tst = '0;
    logic       init_done_p = 0, switch_p = 0, bus_busy = 0, recov_req = 0, lost_p = 0;
    logic       rd_en = 0;
    logic [3:0] rd_pulse = '0;
    logic [9:0] irq_mask = '0;
    logic [5:0] status;
    logic [1:0] irq_n;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dmsr_status u0 (
        .clk(clk), .rst(rst), .ext_irq_n(ext_irq_n), .self_tst(self_tst),
        .peer_tst(peer_tst), .init_done_p(init_done_p), .switch_p(switch_p),
        .bus_busy(bus_busy), .recov_req(recov_req), .lost_p(lost_p),
        .rd_en(rd_en), .rd_pulse(rd_pulse), .irq_mask(irq_mask),
        .status(status), .irq_n(irq_n)
    );

    // e | selfA selfB peerA peerB | init sw busy recov lost | rd pulse4 | status6 | irq_n[1:0]
    localparam int NV = 24;
    localparam logic [22:0] TBL [NV] = '{
        23'b0_0000_00000_00000_000000_11, // 0  idle R7
        23'b1_0000_00000_00000_000001_00, // 1  ext low R2
        23'b1_0000_00000_10010_000001_00, // 2  read keeps ext R1 R2
        23'b0_0000_00000_00000_000000_11, // 3  ext high clears R2
        23'b0_1000_00000_00000_000010_10, // 4  self test m0 R3
        23'b0_1000_00000_10010_000010_10, // 5  read keeps test R1
        23'b0_0000_00000_00000_000000_11, // 6  test cleared R3
        23'b0_0001_00000_00000_000010_10, // 7  peer of m1 hits m0 R3
        23'b0_0010_00000_00000_000100_01, // 8  peer of m0 hits m1 R3 R8
        23'b0_0000_00000_00000_000000_11, // 9  idle
        23'b0_0000_10000_00000_001000_00, // 10 init done R6
        23'b0_0000_00000_10001_001000_00, // 11 pulse 1 keeps R4
        23'b0_0000_00000_10010_000000_11, // 12 pulse 2 clears R4
        23'b0_0000_01100_00000_010000_00, // 13 switch busy R6
        23'b0_0000_00000_10010_000000_11, // 14 clear R4
        23'b0_0000_01000_00000_000000_11, // 15 switch idle bus R6
        23'b0_0000_01110_00000_000000_11, // 16 switch during recovery R6
        23'b0_0000_00001_00000_100000_00, // 17 lost R6
        23'b0_0000_00001_10010_100000_00, // 18 set beats clear R5
        23'b0_0000_00000_00010_100000_00, // 19 no strobe keeps R4
        23'b0_0000_00000_10010_000000_11, // 20 clear R4
        23'b1_0000_10000_10010_001001_00, // 21 ext + init under read R5 R2
        23'b1_0000_00000_10010_000001_00, // 22 init clears, ext stays R4 R1
        23'b0_0000_00000_00000_000000_11  // 23 idle
    };

    task automatic check(input string req, input logic [5:0] st_exp, input logic [1:0] irq_exp);
        checks++;
        if (status !== st_exp || irq_n !== irq_exp) begin
            errors++;
            $display("FAIL %s: status=%b irq_n=%b expected status=%b irq_n=%b",
                     req, status, irq_n, st_exp, irq_exp);
        end
    endtask

    task automatic idle_inputs();
        ext_irq_n = 1; self_tst = 0; peer_tst = 0; init_done_p = 0; switch_p = 0;
        bus_busy = 0; recov_req = 0; lost_p = 0; rd_en = 0; rd_pulse = 0;
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: expired expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // reset state with sources active: R7
        ext_irq_n = 0; lost_p = 1;
        step(); step();
        check("R7 reset", 6'b000000, 2'b11);
        @(negedge clk); idle_inputs(); rst = 0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {ext_irq_n, self_tst[0], self_tst[1], peer_tst[0], peer_tst[1],
             init_done_p, switch_p, bus_busy, recov_req, lost_p, rd_en, rd_pulse} = TBL[i][22:8];
            ext_irq_n = ~ext_irq_n;
            step();
            check($sformatf("table vector %0d", i), TBL[i][7:2], TBL[i][1:0]);
        end

        // R8: master 0 masks external, master 1 still sees it
        @(negedge clk); idle_inputs(); irq_mask = 10'b00000_00001; ext_irq_n = 0;
        step();
        check("R8 mask ext m0", 6'b000001, 2'b01);
        // R8: master 1 masks its test flag
        @(negedge clk); ext_irq_n = 1; irq_mask = 10'b00010_00000; peer_tst = 2'b01;
        step();
        check("R8 mask test m1", 6'b000100, 2'b11);
        // R8: lost masked on both, then unmasked
        @(negedge clk); peer_tst = 0; irq_mask = 10'b10000_10000; lost_p = 1;
        step();
        check("R8 lost masked", 6'b100000, 2'b11);
        @(negedge clk); lost_p = 0; irq_mask = '0;
        step();
        check("R8 lost unmasked", 6'b100000, 2'b00);
        // R2: ext still low after a read keeps interrupting
        @(negedge clk); ext_irq_n = 0; rd_en = 1; rd_pulse = 2;
        step();
        check("R2 ext during read", 6'b000001, 2'b00);
        @(negedge clk); rd_en = 0; rd_pulse = 0;
        step();
        check("R2 ext after read", 6'b000001, 2'b00);
        // R7: reset mid-run clears set flags
        @(negedge clk); ext_irq_n = 1; init_done_p = 1;
        step();
        check("R6 init set", 6'b001000, 2'b00);
        @(negedge clk); init_done_p = 0; rst = 1;
        step();
        check("R7 mid reset", 6'b000000, 2'b11);
        @(negedge clk); rst = 0;
        step();
        check("R7 after reset", 6'b000000, 2'b11);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule